// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a flat 20-bit memory address for a 16-bit processor core. For data accesses, it adds an optional base register, an optional index register and a 16-bit displacement to form a 16-bit effective address. It then picks a segment register, shifts that segment left by four bits, and adds the effective address to it. For instruction fetches, it always pairs the code segment with the instruction pointer.

The core presents the current register values, the base and index select codes, the displacement and an optional segment override. It then pulses a request. One clock later the block drives the address with a one-cycle valid flag. Between requests the address output keeps its last value.

Top module: `seg_addr_gen`

## Requirements
- R1: For a data access, the effective address is the sum of the selected base, the selected index and `disp_i`, truncated to 16 bits. Base code 00 selects nothing, 01 selects `bx_i`, 10 selects `bp_i` and 11 selects `sp_i`. Index code 01 selects `si_i`, 10 selects `di_i`, and 00 or 11 selects nothing.
- R2: The physical address is (segment × 16 + effective address) modulo 2^20, so a carry past bit 19 is dropped. Example: with a data segment of 1230h and an offset of 0045h, the result is 12345h.
- R3: When `fetch_i` is high, the address is formed from `cs_i` and `ip_i`. Base, index, displacement and override inputs have no effect. Example: 1234h:0002h gives 12342h.
- R4: With no override on a data access, the block uses `ss_i` when the base code is 10 or 11, and `ds_i` otherwise.
- R5: When `ovr_valid_i` is high on a data access, `ovr_seg_i` replaces the default segment: 00 selects ES, 01 selects CS, 10 selects SS and 11 selects DS.
- R6: `paddr_vld_o` is high in exactly the cycle after a clock edge that samples `req_i` high. In that same cycle, `paddr_o` carries the address computed from the inputs sampled at that edge.
- R7: After an edge that samples `req_i` low, `paddr_o` keeps its previous value whatever the other inputs do.
- R8: While reset is asserted, `paddr_o` is zero and `paddr_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one address per cycle |
| fetch_i | input | 1 | Instruction fetch (CS:IP) when high |
| base_sel_i | input | 2 | Base register select code |
| idx_sel_i | input | 2 | Index register select code |
| disp_i | input | 16 | Displacement |
| ovr_valid_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| bx_i | input | 16 | Base register BX value |
| bp_i | input | 16 | Base pointer value |
| sp_i | input | 16 | Stack pointer value |
| si_i | input | 16 | Source index value |
| di_i | input | 16 | Destination index value |
| ip_i | input | 16 | Instruction pointer value |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| es_i | input | 16 | Extra segment value |
| ss_i | input | 16 | Stack segment value |
| paddr_o | output | 20 | Registered physical address |
| paddr_vld_o | output | 1 | High for one cycle per accepted request |

## Verification
Two selections can compete for the segment in the same cycle. The first case is a segment override that arrives together with a stack-pointer or base-pointer base, which would otherwise pick SS by default. The second case is an override that arrives together with a fetch, which must ignore the override. The bench drives both collisions directly. It also mixes all of them freely in the random phase, where override, fetch and select codes are drawn independently. Each result is judged against a bench model that applies the same order of precedence: fetch first, then override, then the default.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned OFS_W     = 16;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned PA_W      = OFS_W + SEG_SHIFT;

  typedef enum logic [1:0] {
    BASE_NONE = 2'b00,
    BASE_BX   = 2'b01,
    BASE_BP   = 2'b10,
    BASE_SP   = 2'b11
  } base_sel_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'b00,
    IDX_SI   = 2'b01,
    IDX_DI   = 2'b10,
    IDX_RSVD = 2'b11
  } idx_sel_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_code_e;
endpackage

// File: rtl/seg_ea_sum.sv
module seg_ea_sum
  import seg_addr_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         fetch_i,
  input  logic [1:0]   base_sel_i,
  input  logic [1:0]   idx_sel_i,
  input  logic [W-1:0] disp_i,
  input  logic [W-1:0] bx_i,
  input  logic [W-1:0] bp_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] si_i,
  input  logic [W-1:0] di_i,
  input  logic [W-1:0] ip_i,
  output logic [W-1:0] ea_o
);
  logic [W-1:0] base_val;
  logic [W-1:0] idx_val;
  logic [W-1:0] data_ea;

  always_comb begin
    unique case (base_sel_e'(base_sel_i))
      BASE_BX: base_val = bx_i;
      BASE_BP: base_val = bp_i;
      BASE_SP: base_val = sp_i;
      default: base_val = '0;
    endcase
  end

  always_comb begin
    unique case (idx_sel_e'(idx_sel_i))
      IDX_SI:  idx_val = si_i;
      IDX_DI:  idx_val = di_i;
      default: idx_val = '0;
    endcase
  end

  // three-input sum kept at W bits: carries out of the offset are lost
  assign data_ea = base_val + idx_val + disp_i;
  assign ea_o    = fetch_i ? ip_i : data_ea;
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         fetch_i,
  input  logic [1:0]   base_sel_i,
  input  logic         ovr_valid_i,
  input  logic [1:0]   ovr_seg_i,
  input  logic [W-1:0] cs_i,
  input  logic [W-1:0] ds_i,
  input  logic [W-1:0] es_i,
  input  logic [W-1:0] ss_i,
  output logic [W-1:0] seg_o
);
  seg_code_e dflt_code;
  seg_code_e use_code;

  always_comb begin
    if ((base_sel_e'(base_sel_i) == BASE_BP) || (base_sel_e'(base_sel_i) == BASE_SP))
      dflt_code = SEG_SS;
    else
      dflt_code = SEG_DS;
  end

  // precedence: fetch, then override, then default
  always_comb begin
    if (fetch_i)
      use_code = SEG_CS;
    else if (ovr_valid_i)
      use_code = seg_code_e'(ovr_seg_i);
    else
      use_code = dflt_code;
  end

  always_comb begin
    unique case (use_code)
      SEG_ES:  seg_o = es_i;
      SEG_CS:  seg_o = cs_i;
      SEG_SS:  seg_o = ss_i;
      default: seg_o = ds_i;
    endcase
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned W     = OFS_W,
  parameter int unsigned SHIFT = SEG_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic                 fetch_i,
  input  logic [1:0]           base_sel_i,
  input  logic [1:0]           idx_sel_i,
  input  logic [W-1:0]         disp_i,
  input  logic                 ovr_valid_i,
  input  logic [1:0]           ovr_seg_i,
  input  logic [W-1:0]         bx_i,
  input  logic [W-1:0]         bp_i,
  input  logic [W-1:0]         sp_i,
  input  logic [W-1:0]         si_i,
  input  logic [W-1:0]         di_i,
  input  logic [W-1:0]         ip_i,
  input  logic [W-1:0]         cs_i,
  input  logic [W-1:0]         ds_i,
  input  logic [W-1:0]         es_i,
  input  logic [W-1:0]         ss_i,
  output logic [W+SHIFT-1:0]   paddr_o,
  output logic                 paddr_vld_o
);
  localparam int unsigned AW = W + SHIFT;

  // reset: asserted at once, released on a clock edge
  logic rst_meta;
  logic rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic [W-1:0]  ea;
  logic [W-1:0]  seg;
  logic [AW-1:0] pa_calc;
  logic [AW-1:0] pa_d;
  logic [AW-1:0] pa_q;
  logic          vld_d;
  logic          vld_q;

  seg_ea_sum #(.W(W)) u_ea (
    .fetch_i    (fetch_i),
    .base_sel_i (base_sel_i),
    .idx_sel_i  (idx_sel_i),
    .disp_i     (disp_i),
    .bx_i       (bx_i),
    .bp_i       (bp_i),
    .sp_i       (sp_i),
    .si_i       (si_i),
    .di_i       (di_i),
    .ip_i       (ip_i),
    .ea_o       (ea)
  );

  seg_pick #(.W(W)) u_seg (
    .fetch_i     (fetch_i),
    .base_sel_i  (base_sel_i),
    .ovr_valid_i (ovr_valid_i),
    .ovr_seg_i   (ovr_seg_i),
    .cs_i        (cs_i),
    .ds_i        (ds_i),
    .es_i        (es_i),
    .ss_i        (ss_i),
    .seg_o       (seg)
  );

  // segment on a paragraph boundary plus offset, carry past the top dropped
  assign pa_calc = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ea};

  always_comb begin
    vld_d = req_i;
    pa_d  = req_i ? pa_calc : pa_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pa_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      pa_q  <= pa_d;
      vld_q <= vld_d;
    end
  end

  assign paddr_o     = pa_q;
  assign paddr_vld_o = vld_q;

  p_vld_after_req_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    req_i |=> paddr_vld_o);

  p_vld_idle_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_i |=> !paddr_vld_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_i |=> $stable(paddr_o));

  p_fetch_cs_ip_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_i && fetch_i) |=>
      (paddr_o == AW'({$past(cs_i), {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, $past(ip_i)})));

  p_default_ds_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_i && !fetch_i && !ovr_valid_i && base_sel_i == 2'b00 && idx_sel_i == 2'b00) |=>
      (paddr_o == AW'({$past(ds_i), {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, $past(disp_i)})));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, fetch, ovr_v;
  logic [1:0]  base_sel, idx_sel, ovr_seg;
  logic [15:0] disp, bx, bp, sp, si, di, ip, cs, ds, es, ss;
  logic [19:0] paddr;
  logic        vld;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fetch_i(fetch),
    .base_sel_i(base_sel), .idx_sel_i(idx_sel), .disp_i(disp),
    .ovr_valid_i(ovr_v), .ovr_seg_i(ovr_seg),
    .bx_i(bx), .bp_i(bp), .sp_i(sp), .si_i(si), .di_i(di), .ip_i(ip),
    .cs_i(cs), .ds_i(ds), .es_i(es), .ss_i(ss),
    .paddr_o(paddr), .paddr_vld_o(vld)
  );

  function automatic logic [19:0] model();
    logic [15:0] b, x, ea, sg;
    logic [20:0] full;
    case (base_sel)
      2'b01: b = bx;
      2'b10: b = bp;
      2'b11: b = sp;
      default: b = 16'h0;
    endcase
    case (idx_sel)
      2'b01: x = si;
      2'b10: x = di;
      default: x = 16'h0;
    endcase
    ea = 16'((32'(b) + 32'(x) + 32'(disp)) % 32'h10000);
    if (fetch) begin
      ea = ip;
      sg = cs;
    end else if (ovr_v) begin
      case (ovr_seg)
        2'b00: sg = es;
        2'b01: sg = cs;
        2'b10: sg = ss;
        default: sg = ds;
      endcase
    end else if (base_sel == 2'b10 || base_sel == 2'b11) begin
      sg = ss;
    end else begin
      sg = ds;
    end
    full = 21'(sg) * 21'd16 + 21'(ea);
    return full[19:0];
  endfunction

  task automatic check(input bit ok, input string rq, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%05h expected=%05h", rq, act, exp);
    end
  endtask

  task automatic clear_inputs();
    req = 0; fetch = 0; ovr_v = 0; base_sel = 0; idx_sel = 0; ovr_seg = 0;
    disp = 0; bx = 0; bp = 0; sp = 0; si = 0; di = 0; ip = 0;
    cs = 0; ds = 0; es = 0; ss = 0;
  endtask

  // inputs are set at a negedge; result is sampled at the next negedge
  task automatic fire(input string rq, input logic [19:0] exp);
    req = 1;
    @(negedge clk);
    check(vld === 1'b1, {rq, " valid (R6)"}, 20'(vld), 20'h1);
    check(paddr === exp, rq, paddr, exp);
    req = 0;
  endtask

  task automatic randomize_all();
    fetch    = ($urandom % 5) == 0;
    ovr_v    = ($urandom % 3) == 0;
    base_sel = 2'($urandom);
    idx_sel  = 2'($urandom);
    ovr_seg  = 2'($urandom);
    disp = 16'($urandom); bx = 16'($urandom); bp = 16'($urandom);
    sp = 16'($urandom); si = 16'($urandom); di = 16'($urandom);
    ip = 16'($urandom); cs = 16'($urandom); ds = 16'($urandom);
    es = 16'($urandom); ss = 16'($urandom);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%05h expected=%05h", 20'h0, 20'h1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [19:0] last;
    void'($urandom(32'd1357));
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(paddr === 20'h0, "R8 reset address", paddr, 20'h0);
    check(vld === 1'b0, "R8 reset valid", 20'(vld), 20'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3 fetch example
    fetch = 1; cs = 16'h1234; ip = 16'h0002;
    fire("R3 fetch 1234:0002", 20'h12342);

    // R2 data example through default DS
    clear_inputs(); ds = 16'h1230; disp = 16'h0045;
    fire("R2 DS 1230 + 0045", 20'h12345);

    // R1 offset wrap at 16 bits
    clear_inputs(); ds = 16'h2000; bx = 16'hFFFF; base_sel = 2'b01; si = 16'h0002; idx_sel = 2'b01;
    fire("R1 offset wrap", 20'h20001);

    // R2 carry past bit 19 dropped
    clear_inputs(); ds = 16'hFFFF; disp = 16'h0020;
    fire("R2 top wrap", 20'h00010);

    // R4 defaults: BP and SP to SS, BX with DI to DS
    clear_inputs(); ss = 16'h4000; ds = 16'h7000; bp = 16'h0100; base_sel = 2'b10; disp = 16'h0003;
    fire("R4 BP uses SS", 20'h40103);
    base_sel = 2'b11; sp = 16'hFFFE; disp = 16'h0;
    fire("R4 SP uses SS", 20'h4FFFE);
    base_sel = 2'b01; bx = 16'h0010; idx_sel = 2'b10; di = 16'h0005;
    fire("R4 BX+DI uses DS", 20'h70015);

    // R5 override collides with stack default
    clear_inputs(); es = 16'hA000; ss = 16'h4000; bp = 16'h0008; base_sel = 2'b10;
    ovr_v = 1; ovr_seg = 2'b00;
    fire("R5 ES override over BP", 20'hA0008);

    // R3 fetch collides with override: override ignored
    fetch = 1; cs = 16'h0F00; ip = 16'h0123; ovr_seg = 2'b10; disp = 16'h5555;
    fire("R3 fetch ignores override", 20'h0F123);
    last = 20'h0F123;

    // R7 hold with req low while inputs move
    clear_inputs(); ds = 16'h9999; disp = 16'h1111;
    @(negedge clk);
    check(vld === 1'b0, "R6 no valid without req", 20'(vld), 20'h0);
    check(paddr === last, "R7 hold", paddr, last);

    // random mix
    for (int i = 0; i < 400; i++) begin
      randomize_all();
      fire("R1 R2 R4 R5 random", model());
      if ((i % 7) == 3) begin
        last = paddr;
        randomize_all();
        @(negedge clk);
        check(paddr === last, "R7 random hold", paddr, last);
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule